// File: doc/BRIEF.md
# Sixteen-Bit Timebase Counter with Coherent Byte Readout

This block is a free-running 16-bit counter that serves as the shared timebase of a microcontroller's counter array. Software sees it through a small byte-wide register bus. The counter is split into a low byte and a high byte. A control byte holds the count-source select, the run and idle controls, the interrupt enable and the sticky wrap flag. Software can read the full 16-bit value without tearing. Reading the low byte freezes the high byte into a shadow register, and a later read of the high address returns that frozen copy.

The count advances once for each enable pulse from the selected source. The sources are two free-running system-clock prescalers, a pulse from a neighbouring timer, falling edges on an external pin, every system clock, and an external oscillator that is resynchronised and divided by eight. When the count wraps from its maximum to zero, a flag is set. That flag stays set until software writes it to zero. An interrupt request follows the flag whenever the interrupt is enabled. The register bus is a plain single-cycle interface with no back-pressure. Reads return data combinationally in the cycle they are presented, and writes take effect at the next clock edge.

Top module: `timebase_counter`

## Requirements
- R1: After reset the count, the shadow byte and the control byte are all zero, and `irq` is low.
- R2: Register addresses are fixed. Address 0 reads the live low byte, address 1 reads the shadow byte, address 2 reads the control byte, and address 3 reads zero. The control byte holds the source select in bits 2:0, the interrupt enable in bit 3, the idle-stop in bit 4, run in bit 5 and the wrap flag in bit 7. Bit 6 always reads 0.
- R3: A read of address 0 copies the high byte, as it was before that clock edge, into the shadow byte. Reads of address 1 return the shadow byte and never the live high byte.
- R4: Reads of any address never change the count.
- R5: Select 000 advances the count once every 12 clocks, and select 001 advances it once every 4 clocks. Both prescalers run freely from reset.
- R6: Select 010 advances the count on each clock where `tmr0_ovf` is high. Select 100 advances it on every clock. Selects 110 and 111 never advance it.
- R7: Select 011 advances the count once per high-to-low transition of `ext_cnt_in`. The pin passes through two synchroniser flops and an edge detector, so the increment appears three clock edges after the pin changes.
- R8: Select 101 counts rising edges of `ext_osc_in`, which is synchronised the same way, and advances the count on every eighth such edge.
- R9: Advancing from 0xFFFF to 0x0000 sets the wrap flag. Only a write to bit 7 of the control byte changes the flag. When a wrap and a control write fall on the same edge, the flag ends up set.
- R10: `irq` is high exactly when the wrap flag and the interrupt enable are both 1.
- R11: When idle-stop is 1 and `cpu_idle` is high, the count holds. When idle-stop is 0, `cpu_idle` has no effect.
- R12: The count advances only while run is 1. Writes to address 0 or 1 load that byte only while run is 0, and are ignored while run is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (address 0 read updates shadow) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cpu_idle | input | 1 | CPU is in idle mode |
| tmr0_ovf | input | 1 | One-clock overflow pulse from a timer |
| ext_cnt_in | input | 1 | Asynchronous external count pin |
| ext_osc_in | input | 1 | Asynchronous external oscillator, no faster than `clk` |
| irq | output | 1 | Wrap interrupt request |

## Verification
The critical coincidence is a counter wrap on the same edge as a software write to the control byte that clears the flag. The bench preloads 0xFFFE with run off, then starts counting on every clock. It times a control write with bit 7 at zero so that the write lands on the edge where the count rolls over. The expected result is a set flag and a raised `irq`. A second coincidence pairs a low-byte read with the high byte carrying over on the following edges. The shadow must keep the pre-carry value while the live count moves on. A behavioural reference model follows every edge, and the read data and `irq` are compared against it on every cycle.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [2:0] {
    SRC_DIV_SLOW = 3'b000,
    SRC_DIV_FAST = 3'b001,
    SRC_TIMER    = 3'b010,
    SRC_PIN_FALL = 3'b011,
    SRC_SYSCLK   = 3'b100,
    SRC_OSC_DIV  = 3'b101,
    SRC_RSVD_A   = 3'b110,
    SRC_RSVD_B   = 3'b111
  } src_e;

  typedef struct packed {
    logic wrap_flag;
    logic unused;
    logic run;
    logic idle_stop;
    logic wrap_ie;
    src_e src;
  } ctrl_t;
endpackage

// File: rtl/tbc_prescale.sv
module tbc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pulse
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign pulse = (phase == LAST);

  generate
    if (DIV > 1) begin : g_chk
      p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    end
  endgenerate
endmodule

// File: rtl/tbc_sync_edge.sv
module tbc_sync_edge #(
  parameter int STAGES = 2,
  parameter bit FALL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  generate
    if (FALL) begin : g_fall
      assign edge_pulse = chain[STAGES] & ~chain[STAGES-1];
    end else begin : g_rise
      assign edge_pulse = ~chain[STAGES] & chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tbc_source.sv
module tbc_source
  import tbc_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src,
  input  logic tmr_pulse,
  input  logic pin_in,
  input  logic osc_in,
  output logic pulse
);
  localparam int OW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [OW-1:0] OSC_LAST = OW'(OSC_DIV - 1);

  logic slow_p, fast_p, pin_fall, osc_rise, osc_p;
  logic [OW-1:0] osc_cnt;

  tbc_prescale #(.DIV(DIV_SLOW)) u_slow (.clk(clk), .rst_n(rst_n), .pulse(slow_p));
  tbc_prescale #(.DIV(DIV_FAST)) u_fast (.clk(clk), .rst_n(rst_n), .pulse(fast_p));

  tbc_sync_edge #(.STAGES(SYNC_STAGES), .FALL(1'b1)) u_pin (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .edge_pulse(pin_fall));
  tbc_sync_edge #(.STAGES(SYNC_STAGES), .FALL(1'b0)) u_osc (
    .clk(clk), .rst_n(rst_n), .din(osc_in), .edge_pulse(osc_rise));

  always_ff @(posedge clk) begin
    if (!rst_n)        osc_cnt <= '0;
    else if (osc_rise) osc_cnt <= (osc_cnt == OSC_LAST) ? '0 : osc_cnt + 1'b1;
  end

  assign osc_p = osc_rise && (osc_cnt == OSC_LAST);

  always_comb begin
    unique case (src)
      SRC_DIV_SLOW: pulse = slow_p;
      SRC_DIV_FAST: pulse = fast_p;
      SRC_TIMER:    pulse = tmr_pulse;
      SRC_PIN_FALL: pulse = pin_fall;
      SRC_SYSCLK:   pulse = 1'b1;
      SRC_OSC_DIV:  pulse = osc_p;
      default:      pulse = 1'b0;
    endcase
  end

  // R8: two divided-oscillator pulses are never adjacent
  p_osc_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    osc_p |=> !osc_p);
  // R7: a synchronised falling edge lasts one clock
  p_pin_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall);
endmodule

// File: rtl/tbc_core.sv
module tbc_core
  import tbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output ctrl_t             ctrl
);
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shadow;
  logic wr_low, wr_high, wr_ctrl, rd_low, wrap;

  assign wr_low  = bus_wr && (bus_addr == ADDR_LOW);
  assign wr_high = bus_wr && (bus_addr == ADDR_HIGH);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_low  = bus_rd && (bus_addr == ADDR_LOW);
  assign wrap    = tick && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end else if (!ctrl.run) begin
      if (wr_low)  cnt[BYTE_W-1:0]     <= bus_wdata;
      if (wr_high) cnt[CNT_W-1:BYTE_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shadow <= '0;
    else if (rd_low) shadow <= cnt[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl        <= ctrl_t'(bus_wdata);
        ctrl.unused <= 1'b0;
      end
      if (wrap) ctrl.wrap_flag <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_LOW:  bus_rdata = cnt[BYTE_W-1:0];
      ADDR_HIGH: bus_rdata = shadow;
      ADDR_CTRL: bus_rdata = ctrl;
      default:   bus_rdata = '0;
    endcase
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_low && !wr_high) |=> $stable(cnt));
  p_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == $past(cnt) + 1'b1));
  p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ctrl.wrap_flag);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl.wrap_flag) |-> $past(wr_ctrl));
  p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_low |=> $stable(shadow));
endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
  import tbc_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int OSC_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cpu_idle,
  input  logic       tmr0_ovf,
  input  logic       ext_cnt_in,
  input  logic       ext_osc_in,
  output logic       irq
);
  ctrl_t ctrl;
  logic  src_pulse, tick;

  tbc_source #(
    .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .OSC_DIV(OSC_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_source (
    .clk(clk), .rst_n(rst_n), .src(ctrl.src), .tmr_pulse(tmr0_ovf),
    .pin_in(ext_cnt_in), .osc_in(ext_osc_in), .pulse(src_pulse));

  assign tick = src_pulse && ctrl.run && !(ctrl.idle_stop && cpu_idle);

  tbc_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl));

  assign irq = ctrl.wrap_flag && ctrl.wrap_ie;

  // R11: an idle-stopped, idle CPU sees the whole block frozen on the control path
  p_idle_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_idle && ctrl.idle_stop && !bus_wr) |=> $stable(ctrl));
endmodule

// File: tb/timebase_counter_bench.sv
module timebase_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b1;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic cpu_idle = 1'b0, tmr0_ovf = 1'b0, ext_cnt_in = 1'b0, ext_osc_in = 1'b0;
  logic irq;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  timebase_counter u_timebase_counter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_idle(cpu_idle), .tmr0_ovf(tmr0_ovf), .ext_cnt_in(ext_cnt_in),
    .ext_osc_in(ext_osc_in), .irq(irq));

  // reference model state
  logic [15:0] m_cnt;
  logic [7:0]  m_shadow;
  logic [2:0]  m_src;
  logic m_ie, m_idle, m_run, m_flag;
  int m_k, m_oc;
  logic [2:0] m_pin, m_osc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt[7:0];
      2'd1: return m_shadow;
      2'd2: return {m_flag, 1'b0, m_run, m_idle, m_ie, m_src};
      default: return 8'd0;
    endcase
  endfunction

  function automatic string src_tag(input logic [2:0] s);
    case (s)
      3'b000, 3'b001: return "R5";
      3'b011:         return "R7";
      3'b101:         return "R8";
      default:        return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_shadow = 0; m_src = 0; m_ie = 0; m_idle = 0; m_run = 0; m_flag = 0;
      m_k = 0; m_oc = 0; m_pin = 0; m_osc = 0;
    end else begin
      bit p12, p4, fall, rise, op, sel, tk, wrapped, old_run;
      p12 = (m_k % 12) == 11;
      p4  = (m_k % 4) == 3;
      m_k++;
      fall = m_pin[2] && !m_pin[1];
      m_pin = {m_pin[1:0], ext_cnt_in};
      rise = !m_osc[2] && m_osc[1];
      op = rise && (m_oc == 7);
      if (rise) m_oc = (m_oc + 1) % 8;
      m_osc = {m_osc[1:0], ext_osc_in};
      case (m_src)
        3'b000: sel = p12;
        3'b001: sel = p4;
        3'b010: sel = tmr0_ovf;
        3'b011: sel = fall;
        3'b100: sel = 1'b1;
        3'b101: sel = op;
        default: sel = 1'b0;
      endcase
      tk = sel && m_run && !(m_idle && cpu_idle);
      old_run = m_run;
      wrapped = 1'b0;
      if (bus_rd && bus_addr == 2'd0) m_shadow = m_cnt[15:8];
      if (tk) begin
        if (m_cnt == 16'hFFFF) wrapped = 1'b1;
        m_cnt = m_cnt + 16'd1;
      end
      if (bus_wr) begin
        if (bus_addr == 2'd0 && !old_run) m_cnt[7:0] = bus_wdata;
        if (bus_addr == 2'd1 && !old_run) m_cnt[15:8] = bus_wdata;
        if (bus_addr == 2'd2) begin
          m_src = bus_wdata[2:0]; m_ie = bus_wdata[3]; m_idle = bus_wdata[4];
          m_run = bus_wdata[5]; m_flag = bus_wdata[7];
        end
      end
      if (wrapped) m_flag = 1'b1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_rdata == model_rd(bus_addr), {"R2 ", src_tag(m_src)}, bus_rdata, model_rd(bus_addr));
      chk(irq == (m_flag && m_ie), "R10", irq, m_flag && m_ie);
    end
  end

  // asynchronous-style stimulus for pins and the timer pulse
  int pin_hold = 0, osc_hold = 0;
  always @(posedge clk) begin
    #2;
    if (pin_hold >= 2 + int'($urandom % 3)) begin ext_cnt_in = ~ext_cnt_in; pin_hold = 0; end
    else pin_hold++;
    if (osc_hold >= 1 + int'($urandom % 2)) begin ext_osc_in = ~ext_osc_in; osc_hold = 0; end
    else osc_hold++;
    tmr0_ovf = ($urandom % 6) == 0;
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v1, v2;
    repeat (4) @(posedge clk);
    #2; rst_n = 1'b1;
    #1;
    chk(bus_rdata == 8'h00, "R1 low", bus_rdata, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    bus_addr = 2'd2; #1;
    chk(bus_rdata == 8'h00, "R1 ctrl", bus_rdata, 0);
    bus_addr = 2'd0;
    cyc();

    // R5 slow and fast prescalers
    wr(2'd2, 8'h21); peek(2'd0, v1); repeat (40) cyc(); peek(2'd0, v2);
    chk(v2 == v1 + 8'd10, "R5 div4", v2, v1 + 8'd10);
    wr(2'd2, 8'h20); peek(2'd0, v1); repeat (120) cyc(); peek(2'd0, v2);
    chk(v2 == v1 + 8'd10, "R5 div12", v2, v1 + 8'd10);

    // R6 timer pulse, system clock, reserved; R12 write ignored while running
    wr(2'd2, 8'h22); repeat (200) cyc();
    wr(2'd2, 8'h24); peek(2'd0, v1); repeat (25) cyc(); peek(2'd0, v2);
    chk(v2 == v1 + 8'd25, "R6 sysclk", v2, v1 + 8'd25);
    wr(2'd2, 8'h26); peek(2'd0, v1); wr(2'd0, 8'h55); repeat (20) cyc(); peek(2'd0, v2);
    chk(v2 == v1, "R6 reserved / R12 write ignored", v2, v1);
    wr(2'd2, 8'h27); repeat (20) cyc(); peek(2'd0, v2);
    chk(v2 == v1, "R6 reserved 111", v2, v1);

    // R7 external falling edges, R8 divided oscillator
    wr(2'd2, 8'h23); repeat (400) cyc();
    wr(2'd2, 8'h25); repeat (400) cyc();

    // R12 load while stopped
    wr(2'd2, 8'h04); wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    peek(2'd0, v1); chk(v1 == 8'hA5, "R12 load low", v1, 8'hA5);
    repeat (10) cyc(); peek(2'd0, v2); chk(v2 == 8'hA5, "R12 stopped holds", v2, 8'hA5);

    // R3 coherent read across a carry
    wr(2'd0, 8'hFD); wr(2'd1, 8'h12); wr(2'd2, 8'h24);
    cyc();                       // low read edge: shadow takes 0x12, count 0x12FE
    bus_addr = 2'd1;
    cyc(); cyc();                // count now 0x1300
    peek(2'd1, v1); chk(v1 == 8'h12, "R3 shadow frozen", v1, 8'h12);
    bus_addr = 2'd0; cyc(); cyc();
    peek(2'd1, v1); chk(v1 == 8'h13, "R3 shadow refreshed", v1, 8'h13);
    bus_addr = 2'd0;

    // R9/R10 wrap coincident with a flag-clearing control write
    wr(2'd2, 8'h00); wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h2C);             // run starts, count 0xFFFE
    cyc();                       // 0xFFFF
    wr(2'd2, 8'h2C);             // wrap and clearing write on the same edge
    peek(2'd2, v1); chk(v1 == 8'hAC, "R9 hw set wins", v1, 8'hAC);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    repeat (5) cyc(); peek(2'd2, v1); chk(v1[7] == 1'b1, "R9 flag sticky", v1, 8'hAC);
    wr(2'd2, 8'h2C); peek(2'd2, v1); chk(v1 == 8'h2C, "R9 sw clear", v1, 8'h2C);
    chk(irq == 1'b0, "R10 irq dropped", irq, 0);
    wr(2'd2, 8'hA4); #1; chk(irq == 1'b0, "R10 masked", irq, 0);

    // R11 idle stop
    cpu_idle = 1'b1;
    wr(2'd2, 8'h34); peek(2'd0, v1); repeat (10) cyc(); peek(2'd0, v2);
    chk(v2 == v1, "R11 idle holds", v2, v1);
    wr(2'd2, 8'h24); peek(2'd0, v1); repeat (10) cyc(); peek(2'd0, v2);
    chk(v2 == v1 + 8'd10, "R11 idle ignored", v2, v1 + 8'd10);
    cpu_idle = 1'b0;

    // R4 reads of every address leave the count alone
    wr(2'd2, 8'h06); peek(2'd0, v1);
    for (int i = 0; i < 8; i++) begin bus_addr = 2'(i); cyc(); end
    peek(2'd0, v2); chk(v2 == v1, "R4 reads harmless", v2, v1);

    repeat (5) cyc();
    finish_run();
  end
endmodule